// File: doc/BRIEF.md
# Device Register Access Gate

This block sits at the base of a memory-mapped device window. Word 0 of the window is a header register. It holds fixed identification fields (device number, extra-block count, revision) and four permission bits that software sets. The rest of the window is a plain register file. Every access to that register file is checked against the privilege of the requester. Kernel requests always get through. Supervisor and user requests get through only when the matching permission bit is set.

A refused read returns zero. A refused write is dropped. No fault is signalled, and a refused access takes the same number of cycles as an accepted one. The same quiet rules apply to any offset that lies past the end of the window. The window size in bytes is driven on a constant output, so a decoder outside the block can route addresses to it.

The bus uses plain strobes with no back-pressure. A read or write strobe is taken in the cycle it is presented, and read data returns exactly one cycle later, flagged by a valid pulse.

Top module: `dev_access_gate`

## Requirements
- R1: A read of word 0 returns the header: device number in bits 31:24, extra-block count in bits 21:16, revision in bits 15:12, user-write permission in bit 3, user-read in bit 2, supervisor-write in bit 1, supervisor-read in bit 0, and zero in bits 23:22 and 11:4. The header is readable at every privilege level.
- R2: After reset all four permission bits, every register-file word, `rvalid` and `rdata` are 0.
- R3: A read strobe in cycle N gives `rvalid`=1 with the result on `rdata` in cycle N+1, whether the read is allowed or refused. In a cycle that follows no read, `rvalid` and `rdata` are 0.
- R4: Only kernel writes to word 0 change the header, and they change only bits 3:0. Writes to word 0 from any other privilege level leave the header unchanged. The identification fields and zero bits never change.
- R5: Kernel reads and writes to words 1 and up inside the window always take effect, whatever the permission bits hold.
- R6: A user read of a word other than 0 returns zero when user-read (bit 2) is 0, and returns the stored value when it is 1.
- R7: A user write to a word other than 0 is dropped when user-write (bit 3) is 0, and is stored when it is 1.
- R8: Supervisor reads and writes follow the same rules, using supervisor-read (bit 0) and supervisor-write (bit 1).
- R9: A byte offset at or beyond the window size reads as zero, and writes to it change no register.
- R10: `span_bytes` equals (extra-block count + 1) × 64.
- R11: Privilege encoding on `priv`: 2'b10 is kernel, 2'b01 is supervisor, 2'b00 is user. The value 2'b11 is treated as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte offset into the window; bits 1:0 ignored |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| priv | input | 2 | Privilege of the requester (R11 encoding) |
| rdata | output | 32 | Read data, one cycle after the strobe |
| rvalid | output | 1 | High in the cycle `rdata` carries a read result |
| span_bytes | output | ADDR_W+1 | Window size in bytes |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that the window fits in the address range, so every in-window word can be reached. The stimulus issues each read or write on its own step and keeps both strobes low between steps. The out-of-window probes use real byte offsets above the window within the `ADDR_W` range. The bench model updates its permission and word state only after computing each cycle's expected read, which matches the strobe-exclusive assumption.

// File: rtl/dev_gate_pkg.sv
package dev_gate_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUPV = 2'b01,
    PRIV_KERN = 2'b10,
    PRIV_RSVD = 2'b11
  } priv_e;

  typedef struct packed {
    logic usr_wr;
    logic usr_rd;
    logic sup_wr;
    logic sup_rd;
  } perm_t;

  localparam int HDR_W = 32;
endpackage

// File: rtl/dev_hdr_reg.sv
module dev_hdr_reg
  import dev_gate_pkg::*;
#(
  parameter logic [7:0] DEV_ID   = 8'h00,
  parameter int         DEV_SIZE = 0,
  parameter logic [3:0] DEV_REV  = 4'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       wbits,
  output perm_t            perm,
  output logic [HDR_W-1:0] hdr_word
);
  perm_t perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  perm_q <= '0;
    else if (we) perm_q <= perm_t'(wbits);
  end

  assign perm     = perm_q;
  assign hdr_word = {DEV_ID, 2'b00, 6'(DEV_SIZE), DEV_REV, 8'h00, perm_q};

  // R4: permission bits move only on an enabled header write
  assert_perm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(perm_q));
endmodule

// File: rtl/dev_perm_check.sv
module dev_perm_check
  import dev_gate_pkg::*;
(
  input  logic [1:0] priv,
  input  perm_t      perm,
  output logic       rd_ok,
  output logic       wr_ok
);
  always_comb begin
    unique case (priv)
      PRIV_KERN: begin rd_ok = 1'b1;        wr_ok = 1'b1;        end
      PRIV_SUPV: begin rd_ok = perm.sup_rd; wr_ok = perm.sup_wr; end
      default:   begin rd_ok = perm.usr_rd; wr_ok = perm.usr_wr; end
    endcase
  end
endmodule

// File: rtl/dev_regfile.sv
module dev_regfile #(
  parameter int NWORDS = 31,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [NWORDS-1:0][DATA_W-1:0] words;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (we && widx == IDX_W'(i))   q <= wdata;
    end
    assign words[i] = q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NWORDS; k++)
      if (ridx == IDX_W'(k)) rdata = words[k];
  end
endmodule

// File: rtl/dev_access_gate.sv
module dev_access_gate
  import dev_gate_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] DEV_ID   = 8'hA5,
  parameter int         DEV_SIZE = 1,
  parameter logic [3:0] DEV_REV  = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic [1:0]        priv,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [ADDR_W:0]   span_bytes
);
  localparam int TOTAL_WORDS = (DEV_SIZE + 1) * 16;
  localparam int SPAN_BYTES  = TOTAL_WORDS * 4;
  localparam int WIDX_W      = ADDR_W - 2;
  localparam int RF_WORDS    = TOTAL_WORDS - 1;

  logic [WIDX_W-1:0] word;
  logic [WIDX_W-1:0] word_m1;
  logic              in_span, hdr_sel, be_sel;
  logic              rd_ok, wr_ok, hdr_we, rf_we;
  logic [31:0]       hdr_word, rf_rdata, rd_word;
  perm_t             perm;
  logic              unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign word       = addr[ADDR_W-1:2];
  assign word_m1    = word - 1'b1;
  assign in_span    = 32'(word) < 32'(TOTAL_WORDS);
  assign hdr_sel    = (word == '0);
  assign be_sel     = in_span && !hdr_sel;
  assign hdr_we     = wr_en && hdr_sel && (priv == PRIV_KERN);
  assign rf_we      = wr_en && be_sel && wr_ok;

  dev_hdr_reg #(.DEV_ID(DEV_ID), .DEV_SIZE(DEV_SIZE), .DEV_REV(DEV_REV)) u_hdr (
    .clk(clk), .rst_n(rst_n), .we(hdr_we), .wbits(wdata[3:0]),
    .perm(perm), .hdr_word(hdr_word)
  );

  dev_perm_check u_chk (
    .priv(priv), .perm(perm), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  dev_regfile #(.NWORDS(RF_WORDS), .IDX_W(WIDX_W), .DATA_W(32)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(word_m1), .wdata(wdata),
    .ridx(word_m1), .rdata(rf_rdata)
  );

  always_comb begin
    if (!in_span)     rd_word = '0;
    else if (hdr_sel) rd_word = hdr_word;
    else if (rd_ok)   rd_word = rf_rdata;
    else              rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_word : '0;
    end
  end

  assign span_bytes = (ADDR_W + 1)'(SPAN_BYTES);

  // R3: fixed one-cycle read latency, idle output zero
  assert_rvalid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rvalid && rdata == '0));
  // R6 / R8: refused register-file read yields zero
  assert_denied_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && be_sel && priv != PRIV_KERN && !rd_ok) |=> (rdata == '0));
  // R9: out-of-window read yields zero
  assert_out_of_span_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_span) |=> (rdata == '0));
  // R4: non-kernel header write leaves permissions alone
  assert_hdr_nonkernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hdr_sel && priv != PRIV_KERN) |=> $stable(perm));
endmodule

// File: tb/tb_dev_access_gate.sv
module tb_dev_access_gate;
  localparam int         ADDR_W   = 8;
  localparam logic [7:0] DEV_ID   = 8'hA5;
  localparam int         DEV_SIZE = 1;
  localparam logic [3:0] DEV_REV  = 4'h3;
  localparam int         TOTAL    = (DEV_SIZE + 1) * 16;
  localparam logic [1:0] K = 2'b10, S = 2'b01, U = 2'b00, X = 2'b11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, rd_en, wr_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata;
  logic [1:0]        priv;
  logic              rvalid;
  logic [ADDR_W:0]   span_bytes;

  dev_access_gate #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .DEV_SIZE(DEV_SIZE), .DEV_REV(DEV_REV)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .priv(priv), .rdata(rdata), .rvalid(rvalid), .span_bytes(span_bytes)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_mem [TOTAL];
  logic [3:0]  m_perm;

  function automatic logic [31:0] m_hdr();
    return {DEV_ID, 2'b00, 6'(DEV_SIZE), DEV_REV, 8'h00, m_perm};
  endfunction
  function automatic bit m_rd_ok(logic [1:0] p);
    if (p == K) return 1'b1;
    if (p == S) return m_perm[0];
    return m_perm[2];
  endfunction
  function automatic bit m_wr_ok(logic [1:0] p);
    if (p == K) return 1'b1;
    if (p == S) return m_perm[1];
    return m_perm[3];
  endfunction

  task automatic check(string tag, logic av, logic ev, logic [31:0] ad, logic [31:0] ed);
    n_tests++;
    if (av !== ev || ad !== ed) begin
      n_fail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h", tag, av, ad, ev, ed);
    end
  endtask

  // one bus cycle; reference model updates behaviourally, outputs compared after the edge
  task automatic step(bit rd, bit wr, int a, logic [31:0] wd, logic [1:0] p, string tag);
    int w;
    logic [31:0] exp_d;
    rd_en = rd; wr_en = wr; addr = a[ADDR_W-1:0]; wdata = wd; priv = p;
    @(posedge clk);
    w = a / 4;
    exp_d = '0;
    if (rd && w < TOTAL) begin
      if (w == 0) exp_d = m_hdr();
      else if (m_rd_ok(p)) exp_d = m_mem[w];
    end
    if (wr && w < TOTAL) begin
      if (w == 0) begin
        if (p == K) m_perm = wd[3:0];
      end else if (m_wr_ok(p)) m_mem[w] = wd;
    end
    @(negedge clk);
    check(tag, rvalid, rd, rdata, exp_d);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0; priv = U;
    m_perm = 4'h0;
    for (int i = 0; i < TOTAL; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset outputs", rvalid, 1'b0, rdata, 32'h0);
    n_tests++;
    if (span_bytes !== 9'((DEV_SIZE + 1) * 64)) begin
      n_fail++;
      $display("FAIL R10 span: got %0d expected %0d", span_bytes, (DEV_SIZE + 1) * 64);
    end

    step(1, 0, 0,  0, U, "R1 R2 header at reset, user read");
    step(1, 0, 28, 0, K, "R2 regfile reset zero");
    step(0, 0, 0,  0, K, "R3 idle zero");
    step(0, 1, 4,   32'h1111_0001, K, "R5 kernel write w1");
    step(0, 1, 20,  32'h5555_0005, K, "R5 kernel write w5");
    step(0, 1, 127, 32'hDEAD_BEEF, K, "R5 kernel write last word");
    step(1, 0, 4,   0, K, "R5 kernel read w1");
    step(1, 0, 124, 0, K, "R5 kernel read last word");
    step(1, 0, 4, 0, U, "R6 user read denied");
    step(0, 1, 4, 32'hBAD0_0001, U, "R7 user write denied");
    step(1, 0, 4, 0, S, "R8 supervisor read denied");
    step(0, 1, 20, 32'hBAD0_0005, S, "R8 supervisor write denied");
    step(1, 0, 4,  0, K, "R7 w1 kept");
    step(1, 0, 20, 0, K, "R8 w5 kept");
    step(0, 1, 0, 32'h0000_000F, U, "R4 user header write");
    step(0, 1, 0, 32'h0000_000F, S, "R4 supervisor header write");
    step(1, 0, 0, 0, K, "R4 header unchanged");
    step(0, 1, 0, 32'hFFFF_FFFF, K, "R4 kernel header write all ones");
    step(1, 0, 0, 0, S, "R1 R4 header fields fixed");
    step(1, 0, 4, 0, U, "R6 user read granted");
    step(0, 1, 8, 32'h2222_0002, U, "R7 user write granted");
    step(1, 0, 8, 0, S, "R8 supervisor read granted");
    step(0, 1, 0, 32'h0000_0005, K, "R4 grant read only");
    step(1, 0, 8, 0, U, "R6 user read with bit2");
    step(0, 1, 8, 32'h3333_0003, U, "R7 user write without bit3");
    step(0, 1, 20, 32'h4444_0004, S, "R8 supervisor write without bit1");
    step(1, 0, 20, 0, S, "R8 supervisor read with bit0");
    step(0, 1, 0, 32'h0000_0001, K, "R4 grant supervisor read only");
    step(1, 0, 8, 0, X, "R11 reserved acts as user");
    step(1, 0, 8, 0, S, "R11 supervisor distinct");
    step(0, 1, 0, 32'h0000_0000, K, "R4 revoke all");
    step(1, 0, 8, 0, K, "R5 kernel ignores permissions");
    step(0, 1, 128, 32'h7777_7777, K, "R9 write past window");
    step(0, 1, 252, 32'h8888_8888, K, "R9 write top offset");
    step(1, 0, 128, 0, K, "R9 read past window");
    step(1, 0, 252, 0, K, "R9 read top offset");
    step(1, 0, 124, 0, K, "R9 last word untouched");
    step(1, 0, 4,   0, K, "R9 w1 untouched");
    step(0, 0, 0, 0, K, "R3 idle after read");

    done = 1;
    summary();
    $finish;
  end
endmodule